// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped cache that fetch consults with its current program counter. In the same cycle it answers whether the word being fetched is a branch it has seen before, the direction that branch took the last time it resolved, and where it went. It also produces the address fetch should use next. A predicted-taken branch therefore steers fetch to its target in the following cycle, before decode has even looked at the instruction, and costs no bubble. On a miss, or on a hit whose stored outcome is not-taken, fetch simply continues with the next sequential word.

When a branch resolves in execute, the pipeline presents its address, its actual target and its outcome on the update port. The slot chosen by the low word-address bits is written in full: valid bit, the upper address bits as a tag, the target and a one-bit outcome flag. Whatever that slot held before, from the same branch or from a different one, is replaced. The lookup path is purely combinational from the stored array. An update therefore becomes visible one cycle later, and a lookup in the cycle of the write still sees the old contents.

Neither port carries a handshake. A lookup is answered in the cycle it is presented. An update strobe is always taken at the next rising edge, so there is never back-pressure toward fetch or execute. A synchronous reset invalidates every slot.

Top module: `branch_target_buffer`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, every lookup misses (`lk_hit`=0, `lk_taken`=0). An update presented during reset writes nothing.
- R2: `lk_hit` is 1 exactly when the slot at index `lk_pc[IDX_W+1:2]` is valid and its tag equals `lk_pc[PC_W-1:IDX_W+2]`. Here `IDX_W` = log2(`ENTRIES`) and bits [1:0] of the address are ignored. `lk_taken` is 0 on every miss.
- R3: On a hit, `lk_target` equals the target stored in that slot and `lk_taken` equals its stored outcome flag (1 = taken).
- R4: `lk_next_pc` equals `lk_target` when `lk_hit` and `lk_taken` are both 1. Otherwise it equals `lk_pc` + 4, modulo 2^`PC_W`.
- R5: A rising edge with `upd_en`=1 (and `rst`=0) makes the slot indexed by `upd_pc` valid, with the tag of `upd_pc`, target `upd_target` and outcome `upd_taken`. This evicts any different branch that shared the slot.
- R6: A repeated update for the same branch address replaces both its stored target and its outcome flag.
- R7: When an update and a lookup address the same slot in one cycle, the lookup outputs reflect the slot's contents before that update. The new contents appear from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; invalidates all slots |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_hit | output | 1 | Lookup found a valid matching slot |
| lk_taken | output | 1 | Hit and stored outcome is taken |
| lk_target | output | PC_W | Stored target of the matching slot |
| lk_next_pc | output | PC_W | Address fetch should use next |
| upd_en | input | 1 | Resolved-branch write strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Resolved target address |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A fetch lookup and a resolving branch's write can land on the same slot in the same cycle. The bench provokes this by holding a lookup on the slot while the update strobe is raised for it, once with the matching tag and once with a foreign tag. The outputs sampled just before the edge must match the bench's model of the old slot, and the outputs sampled just after the edge must match the new entry. Between these collisions, every word address of a small configuration is swept against the arithmetic model after each write, so evictions and overwrites show up on every index.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // bits below the word address that the buffer never looks at
  localparam int unsigned BYTE_OFS_W = 2;
  // sequential step between instruction words, in bytes
  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TAG_W = PC_W - IDX_W - btb_pkg::BYTE_OFS_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = pc[IDX_W+btb_pkg::BYTE_OFS_W-1:btb_pkg::BYTE_OFS_W];
  assign tag = pc[PC_W-1:IDX_W+btb_pkg::BYTE_OFS_W];
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TAG_W  = PC_W - IDX_W - btb_pkg::BYTE_OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target,
  input  logic             wr_taken,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_target,
  output logic             rd_taken
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [PC_W-1:0]    target_q [ENTRIES];
  logic               taken_q  [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst && wr_en && (wr_idx == IDX_W'(e))) begin
        tag_q[e]    <= wr_tag;
        target_q[e] <= wr_target;
        taken_q[e]  <= wr_taken;
      end
    end
  end

  // read straight from the registers: a same-cycle write is not seen yet
  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_target = target_q[rd_idx];
  assign rd_taken  = taken_q[rd_idx];
endmodule

// File: rtl/btb_steer.sv
module btb_steer #(
  parameter int unsigned PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic            hit,
  input  logic            taken,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] next_pc
);
  logic [PC_W-1:0] seq_pc;
  assign seq_pc  = pc + PC_W'(btb_pkg::WORD_BYTES);
  assign next_pc = (hit && taken) ? target : seq_pc;
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TAG_W  = PC_W - IDX_W - btb_pkg::BYTE_OFS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken
);
  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, upd_tag;
  logic             slot_valid, slot_taken;
  logic [TAG_W-1:0] slot_tag;
  logic [PC_W-1:0]  slot_target;

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_lk (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
  );

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_upd (
    .pc(upd_pc), .idx(upd_idx), .tag(upd_tag)
  );

  btb_store #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(upd_en), .wr_idx(upd_idx), .wr_tag(upd_tag),
    .wr_target(upd_target), .wr_taken(upd_taken),
    .rd_idx(lk_idx), .rd_valid(slot_valid), .rd_tag(slot_tag),
    .rd_target(slot_target), .rd_taken(slot_taken)
  );

  assign lk_hit    = slot_valid && (slot_tag == lk_tag);
  assign lk_taken  = lk_hit && slot_taken;
  assign lk_target = slot_target;

  btb_steer #(.PC_W(PC_W)) u_steer (
    .pc(lk_pc), .hit(lk_hit), .taken(lk_taken),
    .target(slot_target), .next_pc(lk_next_pc)
  );
endmodule

// File: rtl/branch_target_buffer_chk.sv
module branch_target_buffer_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_hit,
  input logic            lk_taken,
  input logic [PC_W-1:0] lk_target,
  input logic [PC_W-1:0] lk_next_pc,
  input logic            upd_en,
  input logic [PC_W-1:0] upd_pc,
  input logic [PC_W-1:0] upd_target,
  input logic            upd_taken
);
  assert_reset_miss_R1: assert property (@(posedge clk)
    $past(rst) |-> !lk_hit);

  assert_taken_needs_hit_R2: assert property (@(posedge clk) disable iff (rst)
    lk_taken |-> lk_hit);

  assert_redirect_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_taken) |-> (lk_next_pc == lk_target));

  assert_sequential_R4: assert property (@(posedge clk) disable iff (rst)
    !lk_taken |-> (lk_next_pc == lk_pc + PC_W'(4)));

  assert_write_visible_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_en) && !$past(rst) && (lk_pc[PC_W-1:2] == $past(upd_pc[PC_W-1:2])))
    |-> (lk_hit && lk_target == $past(upd_target) && lk_taken == $past(upd_taken)));
endmodule

bind branch_target_buffer branch_target_buffer_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
  .lk_target(lk_target), .lk_next_pc(lk_next_pc), .upd_en(upd_en),
  .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken)
);

// File: tb/branch_target_buffer_tb.sv
module branch_target_buffer_tb;
  localparam int PC_W    = 10;
  localparam int ENTRIES = 4;
  localparam int IDX_W   = 2;
  localparam int WORDS   = 1 << (PC_W - 2);

  logic            clk = 0;
  logic            rst = 1;
  logic [PC_W-1:0] lk_pc = '0;
  logic            lk_hit, lk_taken;
  logic [PC_W-1:0] lk_target, lk_next_pc;
  logic            upd_en = 0;
  logic [PC_W-1:0] upd_pc = '0;
  logic [PC_W-1:0] upd_target = '0;
  logic            upd_taken = 0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // arithmetic model of the slots
  bit       m_valid  [ENTRIES];
  int       m_tag    [ENTRIES];
  int       m_target [ENTRIES];
  bit       m_taken  [ENTRIES];

  always #5 clk = ~clk;

  branch_target_buffer #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_target(lk_target), .lk_next_pc(lk_next_pc), .upd_en(upd_en),
    .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken)
  );

  task automatic cmp(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s pc=%0h actual=%0h expected=%0h", req, lk_pc, act, exp);
    end
  endtask

  // compare the outputs for the address currently on lk_pc against the model
  task automatic judge(input string tagname);
    int idx = int'(lk_pc[IDX_W+1:2]);
    int tg  = int'(lk_pc) >> (IDX_W + 2);
    bit eh  = m_valid[idx] && (m_tag[idx] == tg);
    bit et  = eh && m_taken[idx];
    int en  = et ? m_target[idx] : ((int'(lk_pc) + 4) % (1 << PC_W));
    cmp({tagname, " R2 hit"}, int'(lk_hit), int'(eh));
    cmp({tagname, " R3 taken"}, int'(lk_taken), int'(et));
    if (eh) cmp({tagname, " R3 target"}, int'(lk_target), m_target[idx]);
    cmp({tagname, " R4 next"}, int'(lk_next_pc), en);
  endtask

  task automatic sweep(input string tagname);
    for (int w = 0; w < WORDS; w++) begin
      lk_pc = PC_W'(w * 4 + (w % 4)); // low two bits varied, must be ignored (R2)
      #1;
      judge(tagname);
    end
  endtask

  task automatic model_write(input int pc, input int tgt, input bit tk);
    int idx = (pc >> 2) % ENTRIES;
    m_valid[idx]  = 1;
    m_tag[idx]    = pc >> (IDX_W + 2);
    m_target[idx] = tgt;
    m_taken[idx]  = tk;
  endtask

  task automatic write(input int pc, input int tgt, input bit tk);
    @(negedge clk);
    upd_en = 1; upd_pc = PC_W'(pc); upd_target = PC_W'(tgt); upd_taken = tk;
    @(posedge clk);
    model_write(pc, tgt, tk);
    #1 upd_en = 0;
  endtask

  // R7: lookup held on the slot being written in the same cycle
  task automatic collide(input int lpc, input int pc, input int tgt, input bit tk);
    @(negedge clk);
    lk_pc = PC_W'(lpc);
    upd_en = 1; upd_pc = PC_W'(pc); upd_target = PC_W'(tgt); upd_taken = tk;
    #2 judge("R7 before");
    @(posedge clk);
    model_write(pc, tgt, tk);
    #1 upd_en = 0;
    #1 judge("R7 after");
  endtask

  initial begin
    for (int e = 0; e < ENTRIES; e++) begin
      m_valid[e] = 0; m_tag[e] = 0; m_target[e] = 0; m_taken[e] = 0;
    end
    // update presented during reset must write nothing (R1)
    upd_en = 1; upd_pc = 10'h014; upd_target = 10'h200; upd_taken = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0; upd_en = 0;
    sweep("R1 reset");

    for (int i = 0; i < 20; i++) begin
      int pc = ((i * 37 + 5) % WORDS) * 4;
      write(pc, (i * 53 + 11) % (1 << PC_W), (i % 3) != 0);
      sweep("R5 fill");
    end

    // R6: same branch, new target and flipped outcome
    write(10'h0a4, 10'h3f0, 1);
    lk_pc = 10'h0a4; #1 judge("R6 first");
    write(10'h0a4, 10'h120, 0);
    lk_pc = 10'h0a4; #1 judge("R6 second");
    write(10'h0a4, 10'h124, 1);
    sweep("R6 sweep");

    // R5: different tag on the same slot evicts
    write(10'h1a4, 10'h00c, 1);
    lk_pc = 10'h0a4; #1 judge("R5 evicted");
    lk_pc = 10'h1a4; #1 judge("R5 new");

    // R4: wrap of the sequential address at the top word
    lk_pc = 10'h3fc; #1 judge("R4 wrap");

    collide(10'h1a4, 10'h1a4, 10'h2a8, 0);
    collide(10'h1a4, 10'h2a4, 10'h044, 1);
    collide(10'h2a4, 10'h3a0, 10'h0f0, 1);
    sweep("R7 sweep");

    // R1: reset in mid-run clears everything
    @(negedge clk); rst = 1;
    @(posedge clk); #1 rst = 0;
    for (int e = 0; e < ENTRIES; e++) m_valid[e] = 0;
    sweep("R1 rerun");

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule